// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns a 32-bit IEEE single-precision operand into a 32-bit two's-complement or unsigned integer. The caller selects the signedness and a 3-bit rounding mode with each operand. The fraction bits that are dropped are rounded under that mode, and only then is the result compared with the destination range. A value that does not fit, an infinity or a NaN is clamped to a fixed limit and raises the invalid flag. A rounded in-range result that differs from the operand raises the inexact flag.

The converter has one register stage: an operand presented in one cycle gives its result and flags after the next rising clock edge. Every cycle is treated as a new conversion. No handshake is needed.

Top module: `fp2int_sat`

## Requirements
- R1: While rst_ni is low, result_o, invalid_o and inexact_o are zero. Otherwise the outputs after a rising edge belong to the operand, signedness and mode sampled at that edge (latency of one cycle, with a new conversion every cycle).
- R2: rmode_i picks the rounding mode: 0 nearest with ties to even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero. For example 2.5 gives 2, 2, 2, 3, 3 under modes 0 to 4.
- R3: The codes 5, 6 and 7 on rmode_i round exactly as mode 0 does.
- R4: With unsigned_i=0 the valid range after rounding is -2^31..2^31-1. A result below that range or -inf gives 0x80000000. A result above it or +inf gives 0x7FFFFFFF. Either case sets invalid_o.
- R5: With unsigned_i=1 the valid range after rounding is 0..2^32-1. A negative result or -inf gives 0. A result above 2^32-1 or +inf gives 0xFFFFFFFF. Either case sets invalid_o.
- R6: Any NaN (quiet or signaling, either sign) gives 0x7FFFFFFF when signed and 0xFFFFFFFF when unsigned, and sets invalid_o.
- R7: The range test uses the rounded value. With unsigned_i=1, a negative operand that rounds to zero returns 0 with invalid_o clear.
- R8: inexact_o is set when the operand is finite, the result is in range and the rounded result differs from the operand. inexact_o is never set together with invalid_o.
- R9: Subnormal operands are treated as tiny nonzero values. They give 0 or a magnitude of 1 as the mode directs, and they set inexact_o (or invalid_o when an unsigned result rounds to -1).
- R10: +0 and -0 give 0 with both flags clear, in either signedness.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Single-precision operand |
| unsigned_i | input | 1 | 1: unsigned result, 0: signed result |
| rmode_i | input | 3 | Rounding mode code |
| result_o | output | 32 | Integer result, registered |
| invalid_o | output | 1 | Result was clamped (out of range, infinity or NaN) |
| inexact_o | output | 1 | In-range result differs from the operand |

## Verification
Rounding and range clamping act in the same cycle. A rounding increment can move a value across the lower unsigned limit. The bench provokes this with small negative operands in unsigned mode under several rounding modes: -0.3 and -0.7 rounding either to -0 (valid, inexact) or to -1 (clamped to 0, invalid). The same interaction is tested with negative subnormals under downward rounding. Each vector is judged on the result and on which of the two flags is raised, since the result value alone cannot tell a legal zero from a clamped one.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int INT_W  = 32;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  // fraction bits kept below the binary point: guard plus sticky span
  localparam int FRAC_W = MAN_W + 3;
  localparam int WIDE_W = INT_W + FRAC_W;
  localparam int SH_W   = $clog2(WIDE_W);
  localparam int E_LOW  = BIAS + MAN_W - FRAC_W;
  localparam int E_OVF  = BIAS + INT_W;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rmode_e;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [FP_W-1:0]  operand_i,
  output logic             sign_o,
  output logic             nan_o,
  output logic             inf_o,
  output logic             huge_o,
  output logic             tiny_o,
  output logic [SH_W-1:0]  shift_o,
  output logic [SIG_W-1:0] sig_o
);
  logic [EXP_W-1:0] exp_raw, exp_eff, exp_off;
  logic [MAN_W-1:0] man;
  logic             exp_max, exp_zero;

  assign sign_o   = operand_i[FP_W-1];
  assign exp_raw  = operand_i[FP_W-2:MAN_W];
  assign man      = operand_i[MAN_W-1:0];
  assign exp_max  = &exp_raw;
  assign exp_zero = ~|exp_raw;
  // subnormals share the minimum normal scale
  assign exp_eff  = exp_zero ? EXP_W'(1) : exp_raw;
  assign sig_o    = {~exp_zero, man};

  assign nan_o  = exp_max & (|man);
  assign inf_o  = exp_max & ~(|man);
  assign huge_o = ~exp_max & (exp_raw >= EXP_W'(E_OVF));
  assign tiny_o = exp_eff < EXP_W'(E_LOW);

  assign exp_off = exp_eff - EXP_W'(E_LOW);
  assign shift_o = (tiny_o | huge_o | exp_max) ? '0 : exp_off[SH_W-1:0];
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
(
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             tiny_i,
  input  logic             sign_i,
  input  rmode_e           rmode_i,
  output logic [INT_W:0]   mag_o,
  output logic             lost_o
);
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0]  int_part;
  logic              guard, sticky, any_lost, bump;

  assign wide     = {{(WIDE_W-SIG_W){1'b0}}, sig_i} << shift_i;
  assign int_part = tiny_i ? '0 : wide[WIDE_W-1:FRAC_W];
  assign guard    = tiny_i ? 1'b0 : wide[FRAC_W-1];
  assign sticky   = tiny_i ? (|sig_i) : (|wide[FRAC_W-2:0]);
  assign any_lost = guard | sticky;

  always_comb begin
    unique case (rmode_i)
      RM_ZERO:     bump = 1'b0;
      RM_DOWN:     bump = sign_i & any_lost;
      RM_UP:       bump = ~sign_i & any_lost;
      RM_NEAR_MAX: bump = guard;
      default:     bump = guard & (sticky | int_part[0]);
    endcase
  end

  assign mag_o  = {1'b0, int_part} + {{INT_W{1'b0}}, bump};
  assign lost_o = any_lost;
endmodule

// File: rtl/fp2int_clamp.sv
module fp2int_clamp
  import fp2int_pkg::*;
(
  input  logic             uns_i,
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             inf_i,
  input  logic             huge_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             lost_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] U_MAX = {INT_W{1'b1}};
  localparam logic [INT_W:0]   S_NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] lo_lim, hi_lim;
  logic             over, under;

  assign lo_lim = uns_i ? '0 : S_MIN;
  assign hi_lim = uns_i ? U_MAX : S_MAX;

  always_comb begin
    over  = 1'b0;
    under = 1'b0;
    if (uns_i) begin
      under = sign_i & (|mag_i);
      over  = ~sign_i & mag_i[INT_W];
    end else begin
      under = sign_i & (mag_i > S_NEG_LIM);
      over  = ~sign_i & (mag_i >= S_NEG_LIM);
    end
  end

  always_comb begin
    invalid_o = 1'b1;
    inexact_o = 1'b0;
    if (nan_i) begin
      result_o = hi_lim;
    end else if (inf_i | huge_i) begin
      result_o = sign_i ? lo_lim : hi_lim;
    end else if (under) begin
      result_o = lo_lim;
    end else if (over) begin
      result_o = hi_lim;
    end else begin
      invalid_o = 1'b0;
      inexact_o = lost_i;
      result_o  = sign_i ? (INT_W'(0) - mag_i[INT_W-1:0]) : mag_i[INT_W-1:0];
    end
  end
endmodule

// File: rtl/fp2int_sat.sv
module fp2int_sat
  import fp2int_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FP_W-1:0]  operand_i,
  input  logic             unsigned_i,
  input  logic [2:0]       rmode_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  logic             sign, nan, inf, huge, tiny, lost;
  logic [SH_W-1:0]  shift;
  logic [SIG_W-1:0] sig;
  logic [INT_W:0]   mag;
  logic [INT_W-1:0] res_d;
  logic             inv_d, inx_d;

  fp2int_unpack u_unpack (
    .operand_i (operand_i),
    .sign_o    (sign),
    .nan_o     (nan),
    .inf_o     (inf),
    .huge_o    (huge),
    .tiny_o    (tiny),
    .shift_o   (shift),
    .sig_o     (sig)
  );

  fp2int_round u_round (
    .sig_i   (sig),
    .shift_i (shift),
    .tiny_i  (tiny),
    .sign_i  (sign),
    .rmode_i (rmode_e'(rmode_i)),
    .mag_o   (mag),
    .lost_o  (lost)
  );

  fp2int_clamp u_clamp (
    .uns_i     (unsigned_i),
    .sign_i    (sign),
    .nan_i     (nan),
    .inf_i     (inf),
    .huge_i    (huge),
    .mag_i     (mag),
    .lost_i    (lost),
    .result_o  (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      result_o  <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end
endmodule

// File: rtl/fp2int_sat_chk.sv
module fp2int_sat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] operand_i,
  input logic        unsigned_i,
  input logic [31:0] result_o,
  input logic        invalid_o,
  input logic        inexact_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic op_nan, op_zero;
  assign op_nan  = (&operand_i[30:23]) & (|operand_i[22:0]);
  assign op_zero = ~|operand_i[30:0];

  // R8
  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o);

  // R6
  a_r6_nan_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_nan) |->
      invalid_o && result_o == ($past(unsigned_i) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF));

  // R4
  a_r4_signed_limits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(unsigned_i) && invalid_o |->
      (result_o == 32'h8000_0000 || result_o == 32'h7FFF_FFFF));

  // R5
  a_r5_unsigned_limits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(unsigned_i) && invalid_o |->
      (result_o == 32'h0 || result_o == 32'hFFFF_FFFF));

  // R10
  a_r10_zero_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_zero) |-> result_o == 32'h0 && !invalid_o && !inexact_o);
endmodule

bind fp2int_sat fp2int_sat_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .operand_i  (operand_i),
  .unsigned_i (unsigned_i),
  .result_o   (result_o),
  .invalid_o  (invalid_o),
  .inexact_o  (inexact_o)
);

// File: tb/fp2int_sat_tb.sv
`timescale 1ns/100ps
module fp2int_sat_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand_i = '0;
  logic        unsigned_i = 1'b0;
  logic [2:0]  rmode_i = '0;
  logic [31:0] result_o;
  logic        invalid_o, inexact_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fp2int_sat u_dut (.*);

  task automatic judge(input logic [31:0] er, input logic ei, input logic ex, input string tag);
    n_vec++;
    if (result_o !== er || invalid_o !== ei || inexact_o !== ex) begin
      n_bad++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, result_o, invalid_o, inexact_o, er, ei, ex);
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic uns, input logic [2:0] rm,
                       input logic [31:0] er, input logic ei, input logic ex, input string tag);
    @(negedge clk_i);
    operand_i = op; unsigned_i = uns; rmode_i = rm;
    @(negedge clk_i);
    judge(er, ei, ex, tag);
  endtask

  task automatic t_reset;
    operand_i = 32'h7FC0_0000; unsigned_i = 1'b1; rmode_i = 3'd3;
    repeat (3) @(negedge clk_i);
    judge(32'h0, 1'b0, 1'b0, "R1 reset state");
    rst_ni = 1'b1;
  endtask

  task automatic t_pipeline;
    // R1: back-to-back operands, one result per cycle
    @(negedge clk_i); operand_i = 32'h42F6_0000; unsigned_i = 1'b0; rmode_i = 3'd0;
    @(negedge clk_i); judge(32'h0000_007B, 1'b0, 1'b0, "R1 stream 123");
    operand_i = 32'hC2F6_0000;
    @(negedge clk_i); judge(32'hFFFF_FF85, 1'b0, 1'b0, "R1 stream -123");
    operand_i = 32'h4B00_0001;
    @(negedge clk_i); judge(32'h0080_0001, 1'b0, 1'b0, "R1 stream 8388609");
  endtask

  task automatic t_modes;
    apply(32'h4020_0000, 0, 3'd0, 32'd2, 0, 1, "R2 2.5 even");
    apply(32'h4020_0000, 0, 3'd1, 32'd2, 0, 1, "R2 2.5 zero");
    apply(32'h4020_0000, 0, 3'd2, 32'd2, 0, 1, "R2 2.5 down");
    apply(32'h4020_0000, 0, 3'd3, 32'd3, 0, 1, "R2 2.5 up");
    apply(32'h4020_0000, 0, 3'd4, 32'd3, 0, 1, "R2 2.5 away");
    apply(32'hC020_0000, 0, 3'd0, 32'hFFFF_FFFE, 0, 1, "R2 -2.5 even");
    apply(32'hC020_0000, 0, 3'd1, 32'hFFFF_FFFE, 0, 1, "R2 -2.5 zero");
    apply(32'hC020_0000, 0, 3'd2, 32'hFFFF_FFFD, 0, 1, "R2 -2.5 down");
    apply(32'hC020_0000, 0, 3'd3, 32'hFFFF_FFFE, 0, 1, "R2 -2.5 up");
    apply(32'hC020_0000, 0, 3'd4, 32'hFFFF_FFFD, 0, 1, "R2 -2.5 away");
    apply(32'h3FC0_0000, 0, 3'd0, 32'd2, 0, 1, "R2 1.5 even");
    apply(32'h3F00_0000, 0, 3'd4, 32'd1, 0, 1, "R2 0.5 away");
    apply(32'h4A80_0001, 1, 3'd0, 32'h0040_0000, 0, 1, "R2 4194304.5 even");
    apply(32'h4A80_0001, 1, 3'd3, 32'h0040_0001, 0, 1, "R2 4194304.5 up");
  endtask

  task automatic t_reserved;
    apply(32'h4020_0000, 0, 3'd5, 32'd2, 0, 1, "R3 2.5 code5");
    apply(32'h3FC0_0000, 0, 3'd6, 32'd2, 0, 1, "R3 1.5 code6");
    apply(32'hC020_0000, 0, 3'd7, 32'hFFFF_FFFE, 0, 1, "R3 -2.5 code7");
  endtask

  task automatic t_signed_range;
    apply(32'hCF00_0000, 0, 3'd0, 32'h8000_0000, 0, 0, "R4 -2^31 fits");
    apply(32'h4EFF_FFFF, 0, 3'd0, 32'h7FFF_FF80, 0, 0, "R4 largest fit");
    apply(32'h4F00_0000, 0, 3'd0, 32'h7FFF_FFFF, 1, 0, "R4 2^31 clip");
    apply(32'hCF00_0001, 0, 3'd1, 32'h8000_0000, 1, 0, "R4 below -2^31");
    apply(32'h60AD_78EC, 0, 3'd0, 32'h7FFF_FFFF, 1, 0, "R4 1e20 clip");
    apply(32'h7F80_0000, 0, 3'd0, 32'h7FFF_FFFF, 1, 0, "R4 +inf");
    apply(32'hFF80_0000, 0, 3'd0, 32'h8000_0000, 1, 0, "R4 -inf");
  endtask

  task automatic t_unsigned_range;
    apply(32'h4F00_0000, 1, 3'd0, 32'h8000_0000, 0, 0, "R5 2^31 fits");
    apply(32'h4F7F_FFFF, 1, 3'd0, 32'hFFFF_FF00, 0, 0, "R5 largest fit");
    apply(32'h4F80_0000, 1, 3'd0, 32'hFFFF_FFFF, 1, 0, "R5 2^32 clip");
    apply(32'hBF80_0000, 1, 3'd0, 32'h0, 1, 0, "R5 -1.0 clip");
    apply(32'h7F80_0000, 1, 3'd1, 32'hFFFF_FFFF, 1, 0, "R5 +inf");
    apply(32'hFF80_0000, 1, 3'd1, 32'h0, 1, 0, "R5 -inf");
  endtask

  task automatic t_nan;
    apply(32'h7FC0_0000, 0, 3'd0, 32'h7FFF_FFFF, 1, 0, "R6 qnan signed");
    apply(32'hFFC0_0001, 0, 3'd2, 32'h7FFF_FFFF, 1, 0, "R6 neg nan signed");
    apply(32'h7F80_0001, 1, 3'd0, 32'hFFFF_FFFF, 1, 0, "R6 snan unsigned");
    apply(32'hFFC0_0000, 1, 3'd3, 32'hFFFF_FFFF, 1, 0, "R6 neg nan unsigned");
  endtask

  task automatic t_after_round;
    apply(32'hBE99_999A, 1, 3'd1, 32'h0, 0, 1, "R7 -0.3 zero");
    apply(32'hBE99_999A, 1, 3'd0, 32'h0, 0, 1, "R7 -0.3 even");
    apply(32'hBE99_999A, 1, 3'd2, 32'h0, 1, 0, "R7 -0.3 down");
    apply(32'hBF33_3333, 1, 3'd0, 32'h0, 1, 0, "R7 -0.7 even");
    apply(32'hBF33_3333, 1, 3'd3, 32'h0, 0, 1, "R7 -0.7 up");
  endtask

  task automatic t_inexact;
    apply(32'h3F00_0000, 0, 3'd0, 32'h0, 0, 1, "R8 0.5 even");
    apply(32'h42F6_0000, 1, 3'd3, 32'h0000_007B, 0, 0, "R8 exact 123");
    apply(32'h4F80_0000, 1, 3'd3, 32'hFFFF_FFFF, 1, 0, "R8 no inx on clip");
  endtask

  task automatic t_subnormal;
    apply(32'h0000_0001, 0, 3'd0, 32'h0, 0, 1, "R9 sub even");
    apply(32'h0000_0001, 0, 3'd3, 32'd1, 0, 1, "R9 sub up");
    apply(32'h8000_0001, 0, 3'd2, 32'hFFFF_FFFF, 0, 1, "R9 -sub down signed");
    apply(32'h8000_0001, 1, 3'd2, 32'h0, 1, 0, "R9 -sub down unsigned");
    apply(32'h807F_FFFF, 1, 3'd1, 32'h0, 0, 1, "R9 -sub zero unsigned");
  endtask

  task automatic t_zero;
    apply(32'h0000_0000, 0, 3'd3, 32'h0, 0, 0, "R10 +0 signed");
    apply(32'h8000_0000, 1, 3'd2, 32'h0, 0, 0, "R10 -0 unsigned");
  endtask

  initial begin
    t_reset();
    t_pipeline();
    t_modes();
    t_reserved();
    t_signed_range();
    t_unsigned_range();
    t_nan();
    t_after_round();
    t_inexact();
    t_subnormal();
    t_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule